// File: doc/BRIEF.md
# Channel Error Logout Sequencer

When a channel raises an error, this block freezes a snapshot of several processor and channel status registers together with a description of the fault. It then writes that snapshot as an eight-byte record into a byte-wide storage write port at fixed low addresses. Once the record is fully stored, it issues a one-cycle interrupt request. The request is typed as a machine-check interrupt or an I/O interrupt, depending on the kind of check that started the logout.

The fault description is packed into a code byte, and its layout depends on whether the failing channel is a burst channel or a byte channel. A two-bit logout code is merged with a saturating error counter into a shared count byte. A check strobe that arrives while a record is being written is kept in a one-deep holding slot and is logged right after the current record. If several strobes arrive during one record, the newest one replaces the held one.

The storage side is a valid/ready stream. While `wr_valid` is high, `wr_addr` and `wr_data` hold steady until the clock edge where `wr_ready` is also high. A byte counts as written only on that edge. The sink may hold `wr_ready` low for any number of cycles, and nothing is lost. The check inputs and the interrupt outputs are plain level/pulse signals. Bit numbering in this brief is LSB = bit 0, unless it says otherwise.

Top module: `chan_logout_seq`

## Requirements
- R1: Record bytes are written in ascending address order, one byte per accepted handshake, from BASE_ADDR (default 0x80) through BASE_ADDR+7. No other address is ever presented.
- R2: Byte contents by offset: +0 trap priority, +1 branch conditions, +2 first channel branch conditions, +3 count byte, +4 second channel branch conditions, +5 channel diagnostic, +6 code byte, +7 device address. Each value is sampled in the cycle of the strobe that started the record.
- R3: When `chan_burst`=1, the code byte is {0, 1, timeout flag, timeout count[3:0], trap flag}, written from bit 7 down to bit 0.
- R4: When `chan_burst`=0, the code byte is {0, 0, 1, timeout flag, misc[2:0], trap flag}, written from bit 7 down to bit 0.
- R5: In the count byte, bits 6:5 hold the logout code. The code is 2'b11 when `chk_kind`=2'b10 (interface check) and 2'b00 for every other kind (2'b00 machine check, 2'b01 channel control check, 2'b11 treated as a channel control check). Bit 7 carries counter bit 5, and bits 4:0 carry counter bits 4:0.
- R6: The error counter is six bits wide and is cleared by reset. It increments on every check strobe and saturates at 63. A record carries the counter value that includes its own strobe.
- R7: `busy` and `wr_valid` go high on the edge that samples a strobe taken while idle. They stay high until the edge that accepts the +7 byte. While `wr_ready` is low, `wr_addr` and `wr_data` do not change.
- R8: `irq_valid` pulses for exactly one cycle, in the cycle after the +7 byte is accepted. `irq_mchk`=1 marks a machine-check interrupt (kind 2'b00). `irq_mchk`=0 marks an I/O interrupt (all other kinds).
- R9: A strobe sampled while busy is not dropped. Its snapshot starts writing right after the current record finishes, with no idle cycle in between. A later strobe in the same busy period replaces the held snapshot. A strobe on the edge that finishes a record, when nothing is held, starts the next record at once.
- R10: During and right after reset, `busy`, `wr_valid` and `irq_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chk_strobe | input | 1 | One-cycle check report |
| chk_kind | input | 2 | 00 machine, 01 channel control, 10 interface, 11 as channel control |
| chan_burst | input | 1 | 1 burst channel, 0 byte channel |
| tmo_flag | input | 1 | Timeout occurred |
| trap_flag | input | 1 | Status trap or chained to a command word |
| tmo_count | input | 4 | Timeout counter bits |
| misc_bits | input | 3 | Byte-channel miscellaneous bits |
| reg_trap_prio | input | 8 | Trap priority register |
| reg_branch | input | 8 | Branch conditions register |
| reg_chbr_a | input | 8 | First channel branch conditions register |
| reg_chbr_b | input | 8 | Second channel branch conditions register |
| reg_diag | input | 8 | Channel diagnostic register |
| dev_addr | input | 8 | Device address |
| wr_valid | output | 1 | Storage write request |
| wr_ready | input | 1 | Storage accepts the byte |
| wr_addr | output | ADDR_W | Storage byte address |
| wr_data | output | 8 | Storage byte data |
| busy | output | 1 | Record in progress |
| irq_valid | output | 1 | Interrupt request pulse |
| irq_mchk | output | 1 | 1 machine-check type, 0 I/O type |

## Verification
The main function is driven with every check kind on both channel kinds, using random register values. This shows whether the code-byte layout follows the channel kind and whether the logout code and interrupt type follow the check kind. Each pattern runs once with the sink always ready and once with random back-pressure. The back-pressure runs separate correct handshake holding from a design that advances on its own. Strobes that arrive during a record are placed at several offsets around the final write and also sent in bursts. These show whether a held strobe is kept, replaced, or started on the same edge as the finish. A long run of logouts pushes the counter past 63 to expose missing saturation.

// File: rtl/chlog_pkg.sv
package chlog_pkg;
  localparam int REC_BYTES = 8;
  localparam int IDX_W     = $clog2(REC_BYTES);
  localparam int CNT_W     = 6;

  typedef enum logic [1:0] {
    CK_MACHINE = 2'b00,
    CK_CHANCTL = 2'b01,
    CK_IFACE   = 2'b10,
    CK_SPARE   = 2'b11
  } chk_kind_e;

  typedef enum int {
    OFS_TRAP = 0, OFS_BRANCH = 1, OFS_CHBR_A = 2, OFS_COUNT = 3,
    OFS_CHBR_B = 4, OFS_DIAG = 5, OFS_CODE = 6, OFS_DEV = 7
  } rec_ofs_e;

  typedef logic [REC_BYTES-1:0][7:0] rec_bytes_t;

  typedef struct packed {
    logic       mchk;
    rec_bytes_t bytes;
  } rec_t;
endpackage

// File: rtl/chlog_errcnt.sv
module chlog_errcnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt_next
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_comb begin
    if (cnt_q == CNT_MAX) cnt_next = cnt_q;
    else                  cnt_next = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= cnt_next;
  end
endmodule

// File: rtl/chlog_format.sv
module chlog_format
  import chlog_pkg::*;
(
  input  logic [1:0]       chk_kind,
  input  logic             chan_burst,
  input  logic             tmo_flag,
  input  logic             trap_flag,
  input  logic [3:0]       tmo_count,
  input  logic [2:0]       misc_bits,
  input  logic [7:0]       reg_trap_prio,
  input  logic [7:0]       reg_branch,
  input  logic [7:0]       reg_chbr_a,
  input  logic [7:0]       reg_chbr_b,
  input  logic [7:0]       reg_diag,
  input  logic [7:0]       dev_addr,
  input  logic [CNT_W-1:0] err_cnt,
  output rec_t             rec
);
  chk_kind_e  kind;
  logic [1:0] logout_code;
  logic [7:0] code_byte;
  logic [7:0] count_byte;

  assign kind        = chk_kind_e'(chk_kind);
  assign logout_code = (kind == CK_IFACE) ? 2'b11 : 2'b00;

  // Channel-kind dependent packing; leading marker bits differ per layout.
  always_comb begin
    if (chan_burst) code_byte = {2'b01, tmo_flag, tmo_count, trap_flag};
    else            code_byte = {3'b001, tmo_flag, misc_bits, trap_flag};
  end

  // Logout code sits in bits 6:5, counter fills the rest.
  assign count_byte = {err_cnt[5], logout_code, err_cnt[4:0]};

  always_comb begin
    rec.mchk              = (kind == CK_MACHINE);
    rec.bytes             = '0;
    rec.bytes[OFS_TRAP]   = reg_trap_prio;
    rec.bytes[OFS_BRANCH] = reg_branch;
    rec.bytes[OFS_CHBR_A] = reg_chbr_a;
    rec.bytes[OFS_COUNT]  = count_byte;
    rec.bytes[OFS_CHBR_B] = reg_chbr_b;
    rec.bytes[OFS_DIAG]   = reg_diag;
    rec.bytes[OFS_CODE]   = code_byte;
    rec.bytes[OFS_DEV]    = dev_addr;
  end
endmodule

// File: rtl/chlog_writer.sv
module chlog_writer
  import chlog_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  rec_t              rec_in,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              busy,
  output logic              irq_valid,
  output logic              irq_mchk
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_BYTES - 1);

  rec_t             act_q, pend_q;
  logic             pend_v_q, busy_q;
  logic [IDX_W-1:0] idx_q;
  logic             irq_q, irq_mchk_q;

  logic accept, finish, start_pend, start_in, to_pend;

  assign accept     = busy_q & wr_ready;
  assign finish     = accept & (idx_q == LAST_IDX);
  assign start_pend = finish & pend_v_q;
  assign start_in   = strobe & (~busy_q | (finish & ~pend_v_q));
  assign to_pend    = strobe & busy_q & ~(finish & ~pend_v_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= '0;
      pend_q     <= '0;
      pend_v_q   <= 1'b0;
      busy_q     <= 1'b0;
      idx_q      <= '0;
      irq_q      <= 1'b0;
      irq_mchk_q <= 1'b0;
    end else begin
      irq_q <= finish;
      if (finish) irq_mchk_q <= act_q.mchk;

      if (start_pend) begin
        act_q <= pend_q;
        idx_q <= '0;
      end else if (start_in) begin
        act_q  <= rec_in;
        idx_q  <= '0;
        busy_q <= 1'b1;
      end else if (finish) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else if (accept) begin
        idx_q <= idx_q + 1'b1;
      end

      if (to_pend) begin
        pend_q   <= rec_in;
        pend_v_q <= 1'b1;
      end else if (start_pend) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  assign wr_valid  = busy_q;
  assign busy      = busy_q;
  assign wr_addr   = BASE_ADDR + ADDR_W'(idx_q);
  assign wr_data   = act_q.bytes[idx_q];
  assign irq_valid = irq_q;
  assign irq_mchk  = irq_mchk_q;
endmodule

// File: rtl/chan_logout_seq.sv
module chan_logout_seq
  import chlog_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_strobe,
  input  logic [1:0]        chk_kind,
  input  logic              chan_burst,
  input  logic              tmo_flag,
  input  logic              trap_flag,
  input  logic [3:0]        tmo_count,
  input  logic [2:0]        misc_bits,
  input  logic [7:0]        reg_trap_prio,
  input  logic [7:0]        reg_branch,
  input  logic [7:0]        reg_chbr_a,
  input  logic [7:0]        reg_chbr_b,
  input  logic [7:0]        reg_diag,
  input  logic [7:0]        dev_addr,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              busy,
  output logic              irq_valid,
  output logic              irq_mchk
);
  logic [CNT_W-1:0] cnt_next;
  rec_t             rec_new;

  chlog_errcnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (chk_strobe),
    .cnt_next (cnt_next)
  );

  chlog_format u_fmt (
    .chk_kind      (chk_kind),
    .chan_burst    (chan_burst),
    .tmo_flag      (tmo_flag),
    .trap_flag     (trap_flag),
    .tmo_count     (tmo_count),
    .misc_bits     (misc_bits),
    .reg_trap_prio (reg_trap_prio),
    .reg_branch    (reg_branch),
    .reg_chbr_a    (reg_chbr_a),
    .reg_chbr_b    (reg_chbr_b),
    .reg_diag      (reg_diag),
    .dev_addr      (dev_addr),
    .err_cnt       (cnt_next),
    .rec           (rec_new)
  );

  chlog_writer #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (chk_strobe),
    .rec_in    (rec_new),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .busy      (busy),
    .irq_valid (irq_valid),
    .irq_mchk  (irq_mchk)
  );
endmodule

// File: rtl/chlog_checker.sv
module chlog_checker #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h80
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chk_strobe,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              busy,
  input logic              irq_valid
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(7);
  localparam logic [ADDR_W-1:0] CODE_ADDR = BASE_ADDR + ADDR_W'(6);

  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (ADDR_W'(wr_addr - BASE_ADDR) < ADDR_W'(8))); // R1

  AST_ADDR_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_addr != LAST_ADDR) |=>
      (wr_valid && wr_addr == ADDR_W'($past(wr_addr) + 1'b1))); // R1

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R7

  AST_STROBE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && chk_strobe) |=> busy); // R7

  AST_CODE_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == CODE_ADDR) |->
      (wr_data[7:6] == 2'b01 || wr_data[7:5] == 3'b001)); // R3

  AST_IRQ_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_addr == LAST_ADDR) |=> irq_valid); // R8

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid); // R8
endmodule

bind chan_logout_seq chlog_checker #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chk_strobe (chk_strobe),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .busy       (busy),
  .irq_valid  (irq_valid)
);

// File: tb/chan_logout_seq_test.sv
`timescale 1ns/1ps
module chan_logout_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chk_strobe = 1'b0;
  logic [1:0] chk_kind = 2'b00;
  logic       chan_burst = 1'b0, tmo_flag = 1'b0, trap_flag = 1'b0;
  logic [3:0] tmo_count = '0;
  logic [2:0] misc_bits = '0;
  logic [7:0] reg_trap_prio = '0, reg_branch = '0, reg_chbr_a = '0;
  logic [7:0] reg_chbr_b = '0, reg_diag = '0, dev_addr = '0;
  logic       wr_ready = 1'b1;
  logic       wr_valid, busy, irq_valid, irq_mchk;
  logic [7:0] wr_addr, wr_data;

  always #2.5 clk = ~clk;

  chan_logout_seq uut (
    .clk(clk), .rst_n(rst_n), .chk_strobe(chk_strobe), .chk_kind(chk_kind),
    .chan_burst(chan_burst), .tmo_flag(tmo_flag), .trap_flag(trap_flag),
    .tmo_count(tmo_count), .misc_bits(misc_bits), .reg_trap_prio(reg_trap_prio),
    .reg_branch(reg_branch), .reg_chbr_a(reg_chbr_a), .reg_chbr_b(reg_chbr_b),
    .reg_diag(reg_diag), .dev_addr(dev_addr), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
    .irq_valid(irq_valid), .irq_mchk(irq_mchk)
  );

  int n_checks = 0, n_fails = 0, cyc = 0;
  bit rand_ready = 0, done = 0;

  // Behavioural reference: queue of in-flight records (head = being written).
  logic [63:0] qb[$];
  bit          qm[$];
  int          m_idx = 0, m_cnt = 0;
  bit          m_irq = 0, m_irqm = 0;

  function automatic logic [63:0] build_rec(int cnt);
    logic [7:0] code, cbyte;
    logic [63:0] r;
    code  = chan_burst ? {2'b01, tmo_flag, tmo_count, trap_flag}
                       : {3'b001, tmo_flag, misc_bits, trap_flag};
    cbyte = {cnt[5], (chk_kind == 2'b10) ? 2'b11 : 2'b00, cnt[4:0]};
    r = {dev_addr, code, reg_diag, reg_chbr_b, cbyte, reg_chbr_a, reg_branch, reg_trap_prio};
    return r;
  endfunction

  always @(posedge clk) begin
    m_irq = 0;
    if (!rst_n) begin
      qb.delete(); qm.delete(); m_idx = 0; m_cnt = 0;
    end else begin
      if (qb.size() > 0 && wr_ready) begin
        if (m_idx == 7) begin
          m_irq = 1; m_irqm = qm[0];
          void'(qb.pop_front()); void'(qm.pop_front()); m_idx = 0;
        end else m_idx++;
      end
      if (chk_strobe) begin
        if (m_cnt < 63) m_cnt++;
        if (qb.size() >= 2) begin
          qb[1] = build_rec(m_cnt); qm[1] = (chk_kind == 2'b00);
        end else begin
          qb.push_back(build_rec(m_cnt)); qm.push_back(chk_kind == 2'b00);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit eb;
      string t;
      eb = (qb.size() > 0);
      t  = rst_n ? "R7" : "R10";
      check(busy === eb, t, "busy", busy, eb);
      check(wr_valid === eb, t, "wr_valid", wr_valid, eb);
      check(irq_valid === m_irq, rst_n ? "R8" : "R10", "irq_valid", irq_valid, m_irq);
      if (m_irq) check(irq_mchk === m_irqm, "R8", "irq_mchk", irq_mchk, m_irqm);
      if (eb) begin
        logic [7:0] ed;
        ed = qb[0][8*m_idx +: 8];
        check(wr_addr === 8'(8'h80 + m_idx), "R1", "wr_addr", wr_addr, 8'h80 + m_idx);
        case (m_idx)
          3:       t = "R5 R6";
          6:       t = "R3 R4";
          default: t = "R2 R9";
        endcase
        check(wr_data === ed, t, "wr_data", wr_data, ed);
      end
      if (rand_ready) wr_ready = $urandom_range(0, 1);
      else            wr_ready = 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  task automatic fire(input logic [1:0] k, input logic burst);
    @(negedge clk);
    chk_strobe = 1'b1; chk_kind = k; chan_burst = burst;
    tmo_flag = 1'($urandom); trap_flag = 1'($urandom);
    tmo_count = 4'($urandom); misc_bits = 3'($urandom);
    reg_trap_prio = 8'($urandom); reg_branch = 8'($urandom);
    reg_chbr_a = 8'($urandom); reg_chbr_b = 8'($urandom);
    reg_diag = 8'($urandom); dev_addr = 8'($urandom);
    @(negedge clk);
    chk_strobe = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    do begin @(negedge clk); guard++; end while ((busy || qb.size() > 0) && guard < 2000);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;                       // R10 covered by in-reset compares
    repeat (2) @(negedge clk);
    // R2 R3 R4 R5 R8: every kind on both channel types, with and without stall
    for (int rr = 0; rr < 2; rr++) begin
      rand_ready = (rr == 1);
      for (int k = 0; k < 4; k++)
        for (int b = 0; b < 2; b++) begin
          fire(2'(k), 1'(b));
          wait_idle();
        end
    end
    // R9: one held strobe, then bursts that replace the held one
    for (int rr = 0; rr < 2; rr++) begin
      rand_ready = (rr == 1);
      fire(2'b10, 1'b1); repeat (2) @(negedge clk); fire(2'b00, 1'b0);
      wait_idle();
      fire(2'b01, 1'b0); fire(2'b10, 1'b0); fire(2'b00, 1'b1); fire(2'b11, 1'b1);
      wait_idle();
    end
    // R9: strobes placed around the finishing edge
    rand_ready = 0;
    for (int gap = 3; gap <= 9; gap++) begin
      fire(2'b00, 1'b1);
      repeat (gap) @(negedge clk);
      fire(2'b10, 1'b0);
      wait_idle();
    end
    // R6: drive the counter well past saturation
    for (int n = 0; n < 70; n++) begin
      fire(2'(n % 4), 1'(n % 2));
      wait_idle();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule